// File: doc/BRIEF.md
# Downward-Growing Hardware Stack with Limit Watch

The block keeps a last-in, first-out store of sixteen 16-bit words in a small synchronous RAM, addressed by a 4-bit stack pointer. The store fills from the top of the address space downward. A push first moves the pointer down by one and then writes at the new address. A pop reads the word at the current pointer and then moves the pointer up by one. The pointer therefore always names the word that was pushed last. A processor front end uses the block to hold return addresses. A call pushes the address to resume at, and a return pops it. Because every call takes a fresh slot, nested and recursive calls each get back their own address.

The block reports empty and full from an occupancy count. An illegal request is refused: the pointer and the stored words stay as they are, and a one-cycle error pulse names the cause. Software can load two limit registers through a small write port. After every accepted push, the new pointer is compared with the upper limit. After every accepted pop, the new pointer is compared with the lower limit. A match gives a one-cycle hit pulse, so software can see a soft bound well before the hard one.

Requests are plain strobes that the block always takes in the cycle they are presented. The block never stalls a requester. A refused request shows up only on the error pulses. The read side has no back-pressure: the word appears with `pop_valid_o` for exactly one cycle, and the consumer must take it in that cycle.

Top module: `stack_guard`

## Requirements
- R1: While reset is held and right after it, `sp_o` is 0, `empty_o` is 1, `full_o` is 0, both limit registers hold 0, and no error, hit or `pop_valid_o` pulse is present.
- R2: A push without a pop, with the stack not full, decrements `sp_o` by one modulo 16 and stores `push_data_i` at the new pointer. The first push after reset moves `sp_o` from 0 to 15.
- R3: A pop without a push, with the stack not empty, returns the word at the current pointer on `pop_data_o` with `pop_valid_o` high in the cycle after the strobe, and increments `sp_o` by one modulo 16.
- R4: Words come back in reverse order of their pushes, so three nested return addresses come back innermost first.
- R5: `empty_o` is high exactly when no word is held, and `full_o` is high exactly when 16 words are held. The two are never high together.
- R6: A push without a pop while full is refused. `sp_o`, the count and the stored words are unchanged, and `ovf_err_o` is high for the one cycle after the strobe.
- R7: A pop without a push while empty is refused. `sp_o` is unchanged, no `pop_valid_o` appears, and `unf_err_o` is high for the one cycle after the strobe.
- R8: A push and a pop in the same cycle act as push-then-pop. `sp_o` and the stored words are unchanged, no error is raised, and the next cycle shows `pop_valid_o` with `pop_data_o` equal to that cycle's `push_data_i`. This holds even when the stack is full or empty.
- R9: After an accepted push whose new pointer equals the upper limit register, `hi_hit_o` pulses for one cycle. The upper limit register is selected by `lim_sel_i` = 0.
- R10: After an accepted pop whose new pointer equals the lower limit register, `lo_hit_o` pulses for one cycle. The lower limit register is selected by `lim_sel_i` = 1.
- R11: A limit write changes neither `sp_o`, the flags nor the stored words. The new value applies to requests from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push strobe |
| push_data_i | input | 16 | Word to push |
| pop_i | input | 1 | Pop strobe |
| pop_data_o | output | 16 | Popped word, valid with pop_valid_o |
| pop_valid_o | output | 1 | One-cycle mark of a popped word |
| lim_we_i | input | 1 | Limit register write strobe |
| lim_sel_i | input | 1 | 0 selects the upper limit, 1 the lower limit |
| lim_data_i | input | 4 | Limit value to write |
| sp_o | output | 4 | Current stack pointer |
| empty_o | output | 1 | No word held |
| full_o | output | 1 | All 16 words held |
| ovf_err_o | output | 1 | Refused push pulse |
| unf_err_o | output | 1 | Refused pop pulse |
| hi_hit_o | output | 1 | Upper limit reached pulse |
| lo_hit_o | output | 1 | Lower limit reached pulse |

## Verification
The hardest state to reach is a full stack, where the pointer has wrapped back to 0. There, a refused push and a simultaneous push/pop must both leave all sixteen words intact. That damage only becomes visible much later, when the words are popped. The stimulus therefore fills the stack with sixteen distinct words and applies both requests at the full boundary. It then moves the limits and drains everything, so the scoreboard compares every surviving word in LIFO order. Limit hits are placed mid-stack after the limits are reprogrammed, away from the reset values, so a hit cannot be confused with the empty or full boundary.

// File: rtl/stkg_pkg.sv
package stkg_pkg;

  // Which limit register a write goes to.
  typedef enum logic {
    LIM_UPPER = 1'b0,
    LIM_LOWER = 1'b1
  } lim_sel_e;

  // What the pointer logic decided to do in one cycle.
  typedef struct packed {
    logic acc_push;   // push accepted
    logic acc_pop;    // pop accepted
    logic pass;       // push and pop together: data bypass
    logic rej_push;   // push refused (full)
    logic rej_pop;    // pop refused (empty)
  } stk_op_t;

endpackage

// File: rtl/stkg_ram.sv
module stkg_ram #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
  end

  // Registered read: data appears one cycle after the request.
  always_ff @(posedge clk) begin
    if (rd_en_i) rd_data_o <= mem[rd_addr_i];
  end
endmodule

// File: rtl/stkg_ptr.sv
module stkg_ptr
  import stkg_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  output stk_op_t       op_o,
  output logic [AW-1:0] sp_o,
  output logic [AW-1:0] sp_nxt_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          ovf_err_o,
  output logic          unf_err_o
);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = AW + 1;

  logic [AW-1:0] sp_q;
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          empty, full;
  stk_op_t       op;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));

  always_comb begin
    op.pass     = push_i & pop_i;
    op.acc_push = push_i & ~pop_i & ~full;
    op.acc_pop  = pop_i & ~push_i & ~empty;
    op.rej_push = push_i & ~pop_i & full;
    op.rej_pop  = pop_i & ~push_i & empty;
  end

  always_comb begin
    sp_nxt_o = sp_q;
    cnt_nxt  = cnt_q;
    if (op.acc_push) begin
      sp_nxt_o = sp_q - 1'b1;
      cnt_nxt  = cnt_q + 1'b1;
    end else if (op.acc_pop) begin
      sp_nxt_o = sp_q + 1'b1;
      cnt_nxt  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q      <= '0;
      cnt_q     <= '0;
      ovf_err_o <= 1'b0;
      unf_err_o <= 1'b0;
    end else begin
      sp_q      <= sp_nxt_o;
      cnt_q     <= cnt_nxt;
      ovf_err_o <= op.rej_push;
      unf_err_o <= op.rej_pop;
    end
  end

  assign op_o    = op;
  assign sp_o    = sp_q;
  assign empty_o = empty;
  assign full_o  = full;
endmodule

// File: rtl/stkg_lim.sv
module stkg_lim
  import stkg_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  lim_sel_e      sel_i,
  input  logic [AW-1:0] data_i,
  input  logic          acc_push_i,
  input  logic          acc_pop_i,
  input  logic [AW-1:0] sp_nxt_i,
  output logic          hi_hit_o,
  output logic          lo_hit_o
);
  logic [AW-1:0] upper_q, lower_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q <= '0;
      lower_q <= '0;
    end else if (we_i) begin
      if (sel_i == LIM_LOWER) lower_q <= data_i;
      else                    upper_q <= data_i;
    end
  end

  // Compare the pointer the request leaves behind with the limit in force now.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_hit_o <= 1'b0;
      lo_hit_o <= 1'b0;
    end else begin
      hi_hit_o <= acc_push_i & (sp_nxt_i == upper_q);
      lo_hit_o <= acc_pop_i  & (sp_nxt_i == lower_q);
    end
  end
endmodule

// File: rtl/stack_guard.sv
module stack_guard
  import stkg_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] pop_data_o,
  output logic          pop_valid_o,
  input  logic          lim_we_i,
  input  logic          lim_sel_i,
  input  logic [AW-1:0] lim_data_i,
  output logic [AW-1:0] sp_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          ovf_err_o,
  output logic          unf_err_o,
  output logic          hi_hit_o,
  output logic          lo_hit_o
);
  stk_op_t       op;
  logic [AW-1:0] sp, sp_nxt;
  logic [DW-1:0] ram_q, byp_q;
  logic          byp_sel_q;

  stkg_ptr #(.AW(AW)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_i    (push_i),
    .pop_i     (pop_i),
    .op_o      (op),
    .sp_o      (sp),
    .sp_nxt_o  (sp_nxt),
    .empty_o   (empty_o),
    .full_o    (full_o),
    .ovf_err_o (ovf_err_o),
    .unf_err_o (unf_err_o)
  );

  // Push writes at the decremented pointer; pop reads at the current one.
  stkg_ram #(.DW(DW), .AW(AW)) u_ram (
    .clk       (clk),
    .wr_en_i   (op.acc_push),
    .wr_addr_i (sp_nxt),
    .wr_data_i (push_data_i),
    .rd_en_i   (op.acc_pop),
    .rd_addr_i (sp),
    .rd_data_o (ram_q)
  );

  stkg_lim #(.AW(AW)) u_lim (
    .clk        (clk),
    .rst_n      (rst_n),
    .we_i       (lim_we_i),
    .sel_i      (lim_sel_e'(lim_sel_i)),
    .data_i     (lim_data_i),
    .acc_push_i (op.acc_push),
    .acc_pop_i  (op.acc_pop),
    .sp_nxt_i   (sp_nxt),
    .hi_hit_o   (hi_hit_o),
    .lo_hit_o   (lo_hit_o)
  );

  // Simultaneous push and pop: the pushed word goes straight to the read side.
  always_ff @(posedge clk) begin
    if (op.pass) byp_q <= push_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pop_valid_o <= 1'b0;
      byp_sel_q   <= 1'b0;
    end else begin
      pop_valid_o <= op.acc_pop | op.pass;
      byp_sel_q   <= op.pass;
    end
  end

  assign pop_data_o = byp_sel_q ? byp_q : ram_q;
  assign sp_o       = sp;
endmodule

// File: rtl/stack_guard_chk.sv
module stack_guard_chk #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_i,
  input logic [DW-1:0] push_data_i,
  input logic          pop_i,
  input logic [DW-1:0] pop_data_o,
  input logic          pop_valid_o,
  input logic [AW-1:0] sp_o,
  input logic          empty_o,
  input logic          full_o,
  input logic          ovf_err_o,
  input logic          unf_err_o
);
  assert_push_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && !full_o) |=> (sp_o == AW'($past(sp_o) - 1'b1)));

  assert_pop_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && !empty_o) |=> (pop_valid_o && sp_o == AW'($past(sp_o) + 1'b1)));

  assert_flags_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty_o && full_o));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && full_o) |=> (ovf_err_o && $stable(sp_o) && full_o));

  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && empty_o) |=> (unf_err_o && !pop_valid_o && $stable(sp_o)));

  assert_pass_through_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i) |=> ($stable(sp_o) && pop_valid_o && !ovf_err_o && !unf_err_o
                           && pop_data_o == $past(push_data_i)));
endmodule

bind stack_guard stack_guard_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .push_i      (push_i),
  .push_data_i (push_data_i),
  .pop_i       (pop_i),
  .pop_data_o  (pop_data_o),
  .pop_valid_o (pop_valid_o),
  .sp_o        (sp_o),
  .empty_o     (empty_o),
  .full_o      (full_o),
  .ovf_err_o   (ovf_err_o),
  .unf_err_o   (unf_err_o)
);

// File: tb/test_stack_guard.sv
`timescale 1ns/1ps
module test_stack_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_i = 1'b0, pop_i = 1'b0, lim_we_i = 1'b0, lim_sel_i = 1'b0;
  logic [15:0] push_data_i = '0;
  logic [3:0]  lim_data_i = '0;
  logic [15:0] pop_data_o;
  logic        pop_valid_o, empty_o, full_o, ovf_err_o, unf_err_o, hi_hit_o, lo_hit_o;
  logic [3:0]  sp_o;

  always #5 clk = ~clk;

  stack_guard i_stack_guard (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_data_i(push_data_i),
    .pop_i(pop_i), .pop_data_o(pop_data_o), .pop_valid_o(pop_valid_o),
    .lim_we_i(lim_we_i), .lim_sel_i(lim_sel_i), .lim_data_i(lim_data_i),
    .sp_o(sp_o), .empty_o(empty_o), .full_o(full_o), .ovf_err_o(ovf_err_o),
    .unf_err_o(unf_err_o), .hi_hit_o(hi_hit_o), .lo_hit_o(lo_hit_o)
  );

  int n_chk = 0;
  int n_fail = 0;

  // Reference model built from the requirements.
  logic [3:0]  m_sp = '0, m_hi = '0, m_lo = '0;
  int          m_cnt = 0;
  logic [15:0] m_mem [16];
  logic [15:0] exp_q [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // Driver: one request per cycle; the model predicts all outputs and queues pop data.
  task automatic step(input logic pu, input logic po, input logic [15:0] d,
                      input logic lw, input logic ls, input logic [3:0] ld);
    logic [3:0] nsp;
    int         ncnt;
    logic       e_ovf, e_unf, e_hi, e_lo;
    @(negedge clk);
    push_i = pu; pop_i = po; push_data_i = d;
    lim_we_i = lw; lim_sel_i = ls; lim_data_i = ld;
    e_ovf = pu && !po && (m_cnt == 16);
    e_unf = po && !pu && (m_cnt == 0);
    nsp = m_sp; ncnt = m_cnt; e_hi = 1'b0; e_lo = 1'b0;
    if (pu && po) begin
      exp_q.push_back(d);
    end else if (pu && m_cnt < 16) begin
      nsp = m_sp - 4'd1; m_mem[nsp] = d; ncnt++; e_hi = (nsp == m_hi);
    end else if (po && m_cnt > 0) begin
      exp_q.push_back(m_mem[m_sp]); nsp = m_sp + 4'd1; ncnt--; e_lo = (nsp == m_lo);
    end
    @(posedge clk); #2;
    chk(sp_o == nsp, "R2 R3 R11", "pointer", 32'(sp_o), 32'(nsp));
    chk(empty_o == (ncnt == 0), "R5", "empty", 32'(empty_o), 32'(ncnt == 0));
    chk(full_o == (ncnt == 16), "R5", "full", 32'(full_o), 32'(ncnt == 16));
    chk(ovf_err_o == e_ovf, "R6", "overflow pulse", 32'(ovf_err_o), 32'(e_ovf));
    chk(unf_err_o == e_unf, "R7", "underflow pulse", 32'(unf_err_o), 32'(e_unf));
    chk(hi_hit_o == e_hi, "R9", "upper hit", 32'(hi_hit_o), 32'(e_hi));
    chk(lo_hit_o == e_lo, "R10", "lower hit", 32'(lo_hit_o), 32'(e_lo));
    m_sp = nsp; m_cnt = ncnt;
    if (lw) begin
      if (ls) m_lo = ld; else m_hi = ld;
    end
    push_i = 1'b0; pop_i = 1'b0; lim_we_i = 1'b0;
  endtask

  // Monitor: every popped word must match the scoreboard head (R3 R4 R8).
  initial begin
    forever begin
      @(posedge clk); #2;
      if (rst_n && pop_valid_o) begin
        if (exp_q.size() == 0) chk(1'b0, "R3 R7", "unexpected pop_valid", 32'd1, 32'd0);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk(pop_data_o == e, "R4 R8", "pop data", 32'(pop_data_o), 32'(e));
        end
      end
    end
  end

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1: values under reset
    chk(sp_o == 4'd0, "R1", "reset pointer", 32'(sp_o), 32'd0);
    chk(empty_o == 1'b1, "R1", "reset empty", 32'(empty_o), 32'd1);
    chk(full_o == 1'b0, "R1", "reset full", 32'(full_o), 32'd0);
    chk({pop_valid_o, ovf_err_o, unf_err_o, hi_hit_o, lo_hit_o} == 5'd0, "R1",
        "reset pulses", 32'({pop_valid_o, ovf_err_o, unf_err_o, hi_hit_o, lo_hit_o}), 32'd0);
    @(negedge clk); rst_n = 1'b1;

    step(0, 0, 16'h0, 0, 0, 4'h0);          // R1 idle after reset
    step(0, 1, 16'h0, 0, 0, 4'h0);          // R7 pop while empty
    step(0, 0, 16'h0, 0, 0, 4'h0);          // R7 pulse lasts one cycle
    step(1, 1, 16'h5A5A, 0, 0, 4'h0);       // R8 while empty

    // R2 R4: three nested return addresses, then return in reverse order
    step(1, 0, 16'hA001, 0, 0, 4'h0);
    step(1, 0, 16'hA002, 0, 0, 4'h0);
    step(1, 0, 16'hA003, 0, 0, 4'h0);
    for (int i = 0; i < 3; i++) step(0, 1, 16'h0, 0, 0, 4'h0);  // R10 hit at lower=0

    // R5 R9: fill all sixteen slots; upper=0 hits on the last push
    for (int i = 0; i < 16; i++) step(1, 0, 16'h1000 + 16'(i), 0, 0, 4'h0);
    step(1, 0, 16'hDEAD, 0, 0, 4'h0);       // R6 refused push
    step(0, 0, 16'h0, 0, 0, 4'h0);          // R6 pulse lasts one cycle
    step(1, 1, 16'hBEEF, 0, 0, 4'h0);       // R8 while full

    step(0, 0, 16'h0, 1, 1, 4'd8);          // R11 lower limit = 8
    for (int i = 0; i < 8; i++) step(0, 1, 16'h0, 0, 0, 4'h0);  // R10 hit at sp 8
    step(0, 0, 16'h0, 1, 0, 4'd6);          // R11 upper limit = 6
    step(1, 0, 16'h2222, 0, 0, 4'h0);
    step(1, 0, 16'h3333, 0, 0, 4'h0);       // R9 hit at sp 6
    for (int i = 0; i < 10; i++) step(0, 1, 16'h0, 0, 0, 4'h0); // R4 R6 R8 contents intact
    step(0, 1, 16'h0, 0, 0, 4'h0);          // R7 again at the bottom
    step(0, 0, 16'h0, 0, 0, 4'h0);

    chk(exp_q.size() == 0, "R3", "words still expected", 32'(exp_q.size()), 32'd0);
    summary();
    $finish;
  end
endmodule